// File: doc/BRIEF.md
# Trigger Consistency Monitor

This block protects a pulsed beam by testing an external timing trigger against beam pulse starts that are found elsewhere by edge detection on the measured current. The trigger serves only as a cross-check on those pulse edges. Two properties are checked. First, the spacing between trigger strobes must stay inside a programmed minimum and maximum cycle count. Second, every trigger must be followed by a beam pulse start within a programmed number of cycles.

Any breach sets a sticky bit in a fault vector, records which fault came first, and drops a registered permit. The permit returns only on a clear strobe given in a cycle where no fault condition is present. The period limits and the arrival timeout are plain inputs, so the logic that decodes the beam and machine mode sets them for each operating mode.

Top module: `trig_consistency_mon`

## Requirements
- R1: In the cycle after a synchronous reset, permit is 1, the fault vector is 0 and the first-fault code is 0.
- R2: The period is the number of clock cycles between two trigger strobes. A period below the minimum limit sets fault bit 0 (too short).
- R3: A period above the maximum limit sets fault bit 1 (too long).
- R4: Once a trigger has been seen, if the count since it passes the maximum limit with no new trigger, fault bit 2 (missing trigger) is raised. It is raised in every cycle from the trigger cycle plus maximum plus one until the next trigger.
- R5: The first trigger after reset is never checked against the period limits.
- R6: A pulse start in the trigger cycle or within the next timeout cycles is accepted. If none arrives by the trigger cycle plus the timeout, fault bit 3 (arrival timeout) is set in that cycle.
- R7: A new trigger that comes while the previous one is still waiting for its pulse, with no pulse start in that cycle, sets fault bit 3.
- R8: A pulse start with no trigger pending and no trigger in the same cycle sets fault bit 4 (unexpected pulse).
- R9: Fault bits are sticky and show one cycle after the event. Permit is 1 exactly when the fault vector is 0.
- R10: A clear strobe zeroes the fault vector and the first-fault code and raises permit. It has no effect in a cycle where any fault condition is present, for example a trigger that is still missing.
- R11: The first-fault code holds the number of the first fault since reset or clear, as fault bit plus one (1 short, 2 long, 3 missing, 4 timeout, 5 unexpected). When faults arrive together, the lowest number wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | External trigger strobe, one cycle |
| pulse_start_i | input | 1 | Detected beam pulse start strobe |
| per_min_i | input | CNT_W | Minimum allowed trigger period in cycles |
| per_max_i | input | CNT_W | Maximum allowed trigger period in cycles |
| arr_tmo_i | input | TMO_W | Pulse arrival timeout in cycles |
| clear_i | input | 1 | Fault clear strobe |
| permit_o | output | 1 | Beam permit, latched low on fault |
| fault_flags_o | output | 5 | Sticky fault vector |
| first_fault_o | output | 3 | Code of the first fault since clear |

## Verification
Some properties are checked on every cycle. These are the tie between permit and the fault vector, the stickiness of the faults between clears, that permit can rise only through a clear, that the first-fault code points at a bit that is set, and that a pulse start with nothing pending is flagged. The exact cycle where the period limits and the arrival timeout take effect can only be shown by the bench. So can the exemption for the first trigger and the refusal of a clear while a trigger is missing. The bench sweeps trigger periods and pulse delays across both limits to show these.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

    localparam int FC_W = 5;

    typedef enum logic [2:0] {
        FC_NONE  = 3'd0,
        FC_SHORT = 3'd1,
        FC_LONG  = 3'd2,
        FC_MISS  = 3'd3,
        FC_TMO   = 3'd4,
        FC_UNEXP = 3'd5
    } fcode_e;

    typedef struct packed {
        logic unexp;
        logic tmo;
        logic miss;
        logic too_long;
        logic too_short;
    } fault_vec_t;

    function automatic fcode_e first_code(input fault_vec_t v);
        fcode_e c;
        c = FC_NONE;
        if (v.unexp)     c = FC_UNEXP;
        if (v.tmo)       c = FC_TMO;
        if (v.miss)      c = FC_MISS;
        if (v.too_long)  c = FC_LONG;
        if (v.too_short) c = FC_SHORT;
        return c;
    endfunction

endpackage

// File: rtl/tcm_period_chk.sv
module tcm_period_chk #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic [CNT_W-1:0] per_min,
    input  logic [CNT_W-1:0] per_max,
    output logic             ev_short,
    output logic             ev_long,
    output logic             ev_miss
);
    localparam logic [CNT_W-1:0] CNT_SAT = {CNT_W{1'b1}};

    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (trig) begin
            armed_q <= 1'b1;
            cnt_q   <= CNT_W'(1);
        end else if (cnt_q != CNT_SAT) begin
            cnt_q   <= cnt_q + CNT_W'(1);
        end
    end

    always_comb begin
        ev_short = trig && armed_q && (cnt_q < per_min);
        ev_long  = trig && armed_q && (cnt_q > per_max);
        ev_miss  = !trig && armed_q && (cnt_q > per_max);
    end
endmodule

// File: rtl/tcm_arrival_chk.sv
module tcm_arrival_chk #(
    parameter int TMO_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic             pulse,
    input  logic [TMO_W-1:0] tmo,
    output logic             ev_tmo,
    output logic             ev_unexp
);
    logic             pend_q, pend_d;
    logic [TMO_W-1:0] tcnt_q, tcnt_d;

    always_comb begin
        pend_d   = pend_q;
        tcnt_d   = tcnt_q;
        ev_tmo   = 1'b0;
        ev_unexp = 1'b0;
        if (trig) begin
            ev_tmo = pend_q && !pulse;
            pend_d = !pulse;
            tcnt_d = TMO_W'(1);
        end else if (pend_q) begin
            if (pulse) begin
                pend_d = 1'b0;
            end else if (tcnt_q >= tmo) begin
                ev_tmo = 1'b1;
                pend_d = 1'b0;
            end else begin
                tcnt_d = tcnt_q + TMO_W'(1);
            end
        end else if (pulse) begin
            ev_unexp = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            tcnt_q <= '0;
        end else begin
            pend_q <= pend_d;
            tcnt_q <= tcnt_d;
        end
    end
endmodule

// File: rtl/tcm_fault_latch.sv
module tcm_fault_latch
    import tcm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fault_vec_t ev,
    input  logic       clear,
    output fault_vec_t flags,
    output fcode_e     first,
    output logic       permit
);
    logic any_ev;
    assign any_ev = |ev;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags  <= '0;
            first  <= FC_NONE;
            permit <= 1'b1;
        end else if (any_ev) begin
            flags  <= flags | ev;
            permit <= 1'b0;
            if (first == FC_NONE) first <= first_code(ev);
        end else if (clear) begin
            flags  <= '0;
            first  <= FC_NONE;
            permit <= 1'b1;
        end
    end
endmodule

// File: rtl/trig_consistency_mon.sv
module trig_consistency_mon
    import tcm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int TMO_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_i,
    input  logic             pulse_start_i,
    input  logic [CNT_W-1:0] per_min_i,
    input  logic [CNT_W-1:0] per_max_i,
    input  logic [TMO_W-1:0] arr_tmo_i,
    input  logic             clear_i,
    output logic             permit_o,
    output logic [4:0]       fault_flags_o,
    output logic [2:0]       first_fault_o
);
    fault_vec_t ev, flags;
    fcode_e     first;

    tcm_period_chk #(.CNT_W(CNT_W)) u_per (
        .clk(clk), .rst(rst), .trig(trig_i),
        .per_min(per_min_i), .per_max(per_max_i),
        .ev_short(ev.too_short), .ev_long(ev.too_long), .ev_miss(ev.miss)
    );

    tcm_arrival_chk #(.TMO_W(TMO_W)) u_arr (
        .clk(clk), .rst(rst), .trig(trig_i), .pulse(pulse_start_i),
        .tmo(arr_tmo_i), .ev_tmo(ev.tmo), .ev_unexp(ev.unexp)
    );

    tcm_fault_latch u_lat (
        .clk(clk), .rst(rst), .ev(ev), .clear(clear_i),
        .flags(flags), .first(first), .permit(permit_o)
    );

    assign fault_flags_o = flags;
    assign first_fault_o = first;
endmodule

// File: rtl/tcm_checker.sv
module tcm_checker (
    input logic       clk,
    input logic       rst,
    input logic       trig_i,
    input logic       pulse_start_i,
    input logic       clear_i,
    input logic       pend,
    input logic       permit_o,
    input logic [4:0] fault_flags_o,
    input logic [2:0] first_fault_o
);
    logic first_bit_set;
    always_comb first_bit_set = |(fault_flags_o & (5'd1 << (first_fault_o - 3'd1)));

    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (permit_o && fault_flags_o == 5'd0 && first_fault_o == 3'd0));

    // R9
    a_r9_permit_tracks_flags: assert property (@(posedge clk) disable iff (rst)
        permit_o == (fault_flags_o == 5'd0));

    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        !clear_i |=> ((fault_flags_o & $past(fault_flags_o)) == $past(fault_flags_o)));

    // R10
    a_r10_rise_needs_clear: assert property (@(posedge clk) disable iff (rst)
        $rose(permit_o) |-> $past(clear_i));

    // R11
    a_r11_first_in_flags: assert property (@(posedge clk) disable iff (rst)
        (first_fault_o != 3'd0) |-> (first_fault_o <= 3'd5 && first_bit_set));

    // R8
    a_r8_unexpected: assert property (@(posedge clk) disable iff (rst)
        (pulse_start_i && !trig_i && !pend) |=> fault_flags_o[4]);
endmodule

bind trig_consistency_mon tcm_checker u_chk (
    .clk(clk), .rst(rst), .trig_i(trig_i), .pulse_start_i(pulse_start_i),
    .clear_i(clear_i), .pend(u_arr.pend_q), .permit_o(permit_o),
    .fault_flags_o(fault_flags_o), .first_fault_o(first_fault_o)
);

// File: tb/trig_consistency_mon_tb.sv
module trig_consistency_mon_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;
    localparam int TW = 6;
    localparam int PMIN = 4;
    localparam int PMAX = 8;
    localparam int TMO = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trig = 1'b0, pulse = 1'b0, clr = 1'b0;
    logic [CW-1:0] pmin = CW'(PMIN), pmax = CW'(PMAX);
    logic [TW-1:0] tmo = TW'(TMO);
    logic       permit;
    logic [4:0] flags;
    logic [2:0] first;
    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_consistency_mon #(.CNT_W(CW), .TMO_W(TW)) u_dut (
        .clk(clk), .rst(rst), .trig_i(trig), .pulse_start_i(pulse),
        .per_min_i(pmin), .per_max_i(pmax), .arr_tmo_i(tmo), .clear_i(clr),
        .permit_o(permit), .fault_flags_o(flags), .first_fault_o(first)
    );

    task automatic tick(input logic t, input logic p, input logic c);
        trig = t; pulse = p; clr = c;
        @(negedge clk);
        trig = 1'b0; pulse = 1'b0; clr = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(0, 0, 0);
        tick(0, 0, 0);
        rst = 1'b0;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_state(input string req, input int ef, input int ec);
        check(req, int'(flags), ef);
        check(req, int'(first), ec);
        check(req, int'(permit), (ef == 0) ? 1 : 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        check_state("R1 reset", 0, 0);

        // R5: first trigger after reset with count 0 is not short
        tick(1, 1, 0);
        check_state("R5 first trigger", 0, 0);

        // R2 R3 R4 sweep of the period
        for (int p = 2; p <= 12; p++) begin
            int ef, ec;
            do_reset();
            tick(1, 1, 0);
            for (int k = 1; k < p; k++) tick(0, 0, 0);
            tick(1, 1, 0);
            ef = 0; ec = 0;
            if (p < PMIN) begin ef = 1; ec = 1; end
            else if (p == PMAX + 1) begin ef = 2; ec = 2; end
            else if (p > PMAX + 1) begin ef = 6; ec = 3; end
            check_state($sformatf("R2/R3/R4 period %0d", p), ef, ec);
        end

        // R6 sweep of the pulse delay
        for (int d = 0; d <= 5; d++) begin
            int ef, ec;
            do_reset();
            tick(1, d == 0, 0);
            for (int k = 1; k <= 6; k++) tick(0, k == d, 0);
            ef = (d > TMO) ? 24 : 0;
            ec = (d > TMO) ? 4 : 0;
            check_state($sformatf("R6 delay %0d", d), ef, ec);
        end

        // R7 and R11: retrigger while pending, short period at the same time
        do_reset();
        tick(1, 0, 0);
        tick(0, 0, 0);
        tick(1, 0, 0);
        check_state("R7 R11 retrigger", 9, 1);

        // R8 unexpected pulse
        do_reset();
        tick(0, 1, 0);
        check_state("R8 unexpected", 16, 5);
        tick(0, 0, 0);
        check_state("R9 sticky", 16, 5);
        tick(0, 0, 1);
        check_state("R10 clear", 0, 0);

        // R10 clear refused while trigger missing, then accepted
        do_reset();
        tick(1, 1, 0);
        for (int k = 1; k <= 12; k++) tick(0, 0, 0);
        check_state("R4 missing", 4, 3);
        tick(0, 0, 1);
        check_state("R10 clear blocked", 4, 3);
        tick(1, 1, 0);
        check_state("R3 late trigger", 6, 3);
        tick(0, 0, 1);
        check_state("R10 clear accepted", 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule